// File: doc/BRIEF.md
# ATM Cell Header Screening Router

This block sits behind a cell-processing stage that delivers 57-octet slots, one octet per clock. A flag marks the first octet of each slot, and the rest of the slot follows on the next 56 clocks without a gap. Each slot carries the following octets:

- octets 0 to 3: overhead;
- octets 4 to 7: the four cell header octets;
- octet 8: the HEC octet;
- octets 9 to 56: the 48 payload octets.

The router compares the 32-bit header with a programmable value and a don't-care mask for each of four output ports. It then writes the cell, byte by byte, into the FIFO interface of the winning port. A selectable output format decides which octets of the slot are written. The choices are the whole slot, the cell with its HEC, the cell without its HEC, or the payload only.

The header is only complete at octet 7, so the slot passes through an eight-stage delay line. The routing decision is therefore settled before the first octet reaches the output. A cell is dropped and counted in a saturating discard counter in two cases:

- its header matches no port;
- the winning port reports full when the decision is taken.

A dropped cell never leaves a partial cell in any FIFO. The format and the match settings are captured when a slot starts, so changes made in the middle of a slot wait for the next one.

The input-side control is a four-state machine:

| State | Slot octets held | Transition out |
|---|---|---|
| ST_IDLE | none (waits for a slot) | to ST_OVHD when the start flag is seen; this octet is slot octet 0 |
| ST_OVHD | overhead octets 1 to 3 | to ST_HDR after octet 3 |
| ST_HDR | header octets 4 to 7 | to ST_BODY after octet 7; the routing decision is taken in that cycle |
| ST_BODY | octets 8 to 56 | back to ST_IDLE after octet 56 |

The start flag is only looked at in ST_IDLE. Slots may follow one another with no idle cycle between them.

Top module: `cell_screen_router`

## Requirements
- R1: After reset no write strobe or start-of-cell marker is active and the discard count is zero.
- R2: A cell goes to port p when ((header ^ value_p) & mask_p) == 0. The header word takes slot octet 4 as bits 31:24 through octet 7 as bits 7:0. value_p and mask_p sit at bits [32p+31:32p] of the match buses. A mask bit of 0 makes that header bit don't-care.
- R3: When several ports match, the lowest-numbered port receives the cell.
- R4: A cell that matches no port produces no write on any port and adds one to the discard count.
- R5: If the winning port's full input is high in the cycle slot octet 7 is presented, no octet of that cell is written to any port, lower-priority matches included, and the discard count rises by one.
- R6: Format code 0 writes all 57 slot octets in order, with start-of-cell on octet 0.
- R7: Format code 1 writes octets 4 to 56, with start-of-cell on octet 4.
- R8: Format code 2 writes octets 4 to 7 and 9 to 56, skipping the HEC octet 8, with start-of-cell on octet 4.
- R9: Format code 3 writes octets 9 to 56 only, with start-of-cell on octet 9.
- R10: A slot octet presented in input cycle c is written in cycle c+9. Back-to-back slots are handled with no lost or reordered octet.
- R11: Format, match values and masks are sampled with the slot's first octet. A change made during a slot only affects later slots.
- R12: The discard counter saturates at 2^CNT_W-1 and holds there.
- R13: At most one port strobe is active in a cycle. A start-of-cell marker is only active together with its port's strobe, and all ports share one data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_sos | input | 1 | Marks slot octet 0 (looked at only between slots) |
| in_data | input | 8 | Slot octet stream |
| cfg_fmt | input | 2 | Output format code (0: 57, 1: 53, 2: 52, 3: 48 octets) |
| cfg_value | input | NPORT*32 | Per-port header match values |
| cfg_mask | input | NPORT*32 | Per-port header masks, 1 = compare |
| port_full | input | NPORT | Per-port FIFO full flags |
| port_wr | output | NPORT | Per-port write strobes |
| port_soc | output | NPORT | Per-port start-of-cell markers |
| port_data | output | 8 | Shared write data |
| discard_cnt | output | CNT_W | Saturating count of dropped cells |

## Verification
The bench sweeps every format code over a header set that hits each port, covers the overlap and don't-care cases, and misses all ports. Every written octet is compared against its expected port, marker, value and exact cycle. A wrong priority encoder would send the overlapping header to port 1, and a wrong format decode would add or lose the HEC octet or shift the start-of-cell marker. A delay line of the wrong length, or a decision applied too late, shows up as off-cycle writes or as the first octets of a cell going to the previous cell's port. The full and mid-slot-change cases catch a design that reroutes to the next matching port, writes part of a cell, or picks up new settings before the next slot. A long run of unmatched cells then exposes a discard counter that wraps instead of saturating.

// File: rtl/cell_rt_pkg.sv
package cell_rt_pkg;

    localparam int OVH_OCT  = 4;
    localparam int HDR_OCT  = 4;
    localparam int HEC_OCT  = 1;
    localparam int PAY_OCT  = 48;
    localparam int SLOT_OCT = OVH_OCT + HDR_OCT + HEC_OCT + PAY_OCT;
    localparam int HDR_W    = 8 * HDR_OCT;
    localparam int IDX_W    = $clog2(SLOT_OCT);

    typedef logic [IDX_W-1:0] oct_idx_t;

    localparam oct_idx_t IDX_OVH_LAST  = oct_idx_t'(OVH_OCT - 1);
    localparam oct_idx_t IDX_HDR_FIRST = oct_idx_t'(OVH_OCT);
    localparam oct_idx_t IDX_HDR_LAST  = oct_idx_t'(OVH_OCT + HDR_OCT - 1);
    localparam oct_idx_t IDX_HEC       = oct_idx_t'(OVH_OCT + HDR_OCT);
    localparam oct_idx_t IDX_PAY_FIRST = oct_idx_t'(OVH_OCT + HDR_OCT + HEC_OCT);
    localparam oct_idx_t IDX_SLOT_LAST = oct_idx_t'(SLOT_OCT - 1);

    typedef enum logic [1:0] {
        FMT_SLOT    = 2'd0,
        FMT_CELL    = 2'd1,
        FMT_NOHEC   = 2'd2,
        FMT_PAYLOAD = 2'd3
    } out_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OVHD,
        ST_HDR,
        ST_BODY
    } slot_state_e;

    // Whether slot octet i is forwarded under format f
    function automatic logic fmt_keeps(input out_fmt_e f, input oct_idx_t i);
        logic keep;
        keep = 1'b0;
        unique case (f)
            FMT_SLOT:    keep = 1'b1;
            FMT_CELL:    keep = (i >= IDX_HDR_FIRST);
            FMT_NOHEC:   keep = (i >= IDX_HDR_FIRST) && (i != IDX_HEC);
            FMT_PAYLOAD: keep = (i >= IDX_PAY_FIRST);
        endcase
        return keep;
    endfunction

    // First forwarded octet under format f, carries start-of-cell
    function automatic oct_idx_t fmt_first(input out_fmt_e f);
        oct_idx_t first;
        first = '0;
        unique case (f)
            FMT_SLOT:    first = '0;
            FMT_CELL:    first = IDX_HDR_FIRST;
            FMT_NOHEC:   first = IDX_HDR_FIRST;
            FMT_PAYLOAD: first = IDX_PAY_FIRST;
        endcase
        return first;
    endfunction

endpackage

// File: rtl/cell_hdr_match.sv
module cell_hdr_match #(
    parameter  int NPORT = 4,
    parameter  int HDR_W = 32,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic [HDR_W-1:0]       hdr,
    input  logic [NPORT*HDR_W-1:0] value,
    input  logic [NPORT*HDR_W-1:0] mask,
    output logic                   hit,
    output logic [PW-1:0]          port
);

    logic [NPORT-1:0] match;

    // One masked comparator per port
    for (genvar g = 0; g < NPORT; g++) begin : g_cmp
        assign match[g] = ((hdr ^ value[g*HDR_W +: HDR_W]) & mask[g*HDR_W +: HDR_W]) == '0;
    end

    // Lowest-numbered matching port wins
    always_comb begin
        hit  = |match;
        port = '0;
        for (int p = NPORT - 1; p >= 0; p--) begin
            if (match[p]) begin
                port = PW'(p);
            end
        end
    end

endmodule

// File: rtl/cell_delay_line.sv
module cell_delay_line #(
    parameter int W     = 15,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [DEPTH-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg <= {stg[DEPTH-2:0], d};
        end
    end

    assign q = stg[DEPTH-1];

endmodule

// File: rtl/cell_sat_counter.sv
module cell_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/cell_screen_router.sv
module cell_screen_router
    import cell_rt_pkg::*;
#(
    parameter  int NPORT = 4,
    parameter  int CNT_W = 16,
    localparam int PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_sos,
    input  logic [7:0]             in_data,
    input  logic [1:0]             cfg_fmt,
    input  logic [NPORT*HDR_W-1:0] cfg_value,
    input  logic [NPORT*HDR_W-1:0] cfg_mask,
    input  logic [NPORT-1:0]       port_full,
    output logic [NPORT-1:0]       port_wr,
    output logic [NPORT-1:0]       port_soc,
    output logic [7:0]             port_data,
    output logic [CNT_W-1:0]       discard_cnt
);

    localparam int DECIDE_LAT = OVH_OCT + HDR_OCT;
    localparam int DL_W       = 1 + IDX_W + 8;

    slot_state_e state_q, state_nx;
    oct_idx_t    idx_q, cur_idx;
    logic        slot_oct;
    logic        decide;

    // Settings captured at slot start
    out_fmt_e               act_fmt;
    logic [NPORT*HDR_W-1:0] act_value;
    logic [NPORT*HDR_W-1:0] act_mask;

    // Header assembly and matching
    logic [HDR_W-9:0] hdr_q;
    logic [HDR_W-1:0] hdr_full;
    logic             m_hit;
    logic [PW-1:0]    m_port;
    logic             sel_full;

    // Routing decision applied to the delayed slot
    logic          dec_fwd;
    logic [PW-1:0] dec_port;
    out_fmt_e      dec_fmt;

    // Delay line tail
    logic [DL_W-1:0] dl_in, dl_out;
    logic            t_v;
    oct_idx_t        t_idx;
    logic [7:0]      t_data;

    // ---------------- next-state logic ----------------
    always_comb begin
        cur_idx  = (state_q == ST_IDLE) ? '0 : idx_q;
        slot_oct = (state_q != ST_IDLE) || in_sos;
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (in_sos)                     state_nx = ST_OVHD;
            ST_OVHD: if (cur_idx == IDX_OVH_LAST)    state_nx = ST_HDR;
            ST_HDR:  if (cur_idx == IDX_HDR_LAST)    state_nx = ST_BODY;
            ST_BODY: if (cur_idx == IDX_SLOT_LAST)   state_nx = ST_IDLE;
        endcase
        decide = (state_q == ST_HDR) && (cur_idx == IDX_HDR_LAST);
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_nx;
            idx_q   <= slot_oct ? oct_idx_t'(cur_idx + 1'b1) : '0;
        end
    end

    // ---------------- capture, header and decision ----------------
    assign hdr_full = {hdr_q, in_data};

    cell_hdr_match #(
        .NPORT (NPORT),
        .HDR_W (HDR_W)
    ) u_match (
        .hdr   (hdr_full),
        .value (act_value),
        .mask  (act_mask),
        .hit   (m_hit),
        .port  (m_port)
    );

    assign sel_full = port_full[m_port];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_fmt   <= FMT_CELL;
            act_value <= '0;
            act_mask  <= '0;
            hdr_q     <= '0;
            dec_fwd   <= 1'b0;
            dec_port  <= '0;
            dec_fmt   <= FMT_CELL;
        end else begin
            if ((state_q == ST_IDLE) && in_sos) begin
                act_fmt   <= out_fmt_e'(cfg_fmt);
                act_value <= cfg_value;
                act_mask  <= cfg_mask;
            end
            if (state_q == ST_HDR) begin
                hdr_q <= hdr_full[HDR_W-9:0];
            end
            if (decide) begin
                dec_fwd  <= m_hit && !sel_full;
                dec_port <= m_port;
                dec_fmt  <= act_fmt;
            end
        end
    end

    cell_sat_counter #(
        .CNT_W (CNT_W)
    ) u_discard (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (decide && (!m_hit || sel_full)),
        .count (discard_cnt)
    );

    // ---------------- slot delay ----------------
    assign dl_in = {slot_oct, cur_idx, in_data};

    cell_delay_line #(
        .W     (DL_W),
        .DEPTH (DECIDE_LAT)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dl_in),
        .q     (dl_out)
    );

    assign {t_v, t_idx, t_data} = dl_out;

    // ---------------- output process ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_wr   <= '0;
            port_soc  <= '0;
            port_data <= '0;
        end else begin
            port_wr  <= '0;
            port_soc <= '0;
            if (t_v && dec_fwd && fmt_keeps(dec_fmt, t_idx)) begin
                port_wr[dec_port]  <= 1'b1;
                port_soc[dec_port] <= (t_idx == fmt_first(dec_fmt));
                port_data          <= t_data;
            end
        end
    end

endmodule

// File: rtl/cell_screen_router_chk.sv
module cell_screen_router_chk #(
    parameter int NPORT = 4,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPORT-1:0] port_wr,
    input logic [NPORT-1:0] port_soc,
    input logic [CNT_W-1:0] discard_cnt
);

    // R13: a single port written per cycle
    p_one_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_wr));

    // R13: marker never without its strobe
    p_soc_with_wr_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (port_soc & ~port_wr) == '0);

    // R6: start-of-cell never on two consecutive octets
    p_soc_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_soc) |=> !(|port_soc));

    // R4: drops only ever raise the count
    p_cnt_no_decrease_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (discard_cnt >= $past(discard_cnt)));

    // R12: count moves by at most one per cycle
    p_cnt_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((discard_cnt == $past(discard_cnt)) ||
                   (discard_cnt == $past(discard_cnt) + 1'b1)));

    // R12: saturated count stays saturated
    p_cnt_sat_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (discard_cnt == '1) |=> (discard_cnt == '1));

endmodule

bind cell_screen_router cell_screen_router_chk #(
    .NPORT (NPORT),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_wr     (port_wr),
    .port_soc    (port_soc),
    .discard_cnt (discard_cnt)
);

// File: tb/cell_screen_router_bench.sv
module cell_screen_router_bench;

    localparam int NP   = 4;
    localparam int CW   = 4;
    localparam int HW   = 32;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic             in_sos = 1'b0;
    logic [7:0]       in_data = '0;
    logic [1:0]       cfg_fmt = '0;
    logic [NP*HW-1:0] cfg_value = '0;
    logic [NP*HW-1:0] cfg_mask = '0;
    logic [NP-1:0]    port_full = '0;
    logic [NP-1:0]    port_wr, port_soc;
    logic [7:0]       port_data;
    logic [CW-1:0]    discard_cnt;

    cell_screen_router #(.NPORT(NP), .CNT_W(CW)) u_cell_screen_router (
        .clk(clk), .rst_n(rst_n), .in_sos(in_sos), .in_data(in_data),
        .cfg_fmt(cfg_fmt), .cfg_value(cfg_value), .cfg_mask(cfg_mask),
        .port_full(port_full), .port_wr(port_wr), .port_soc(port_soc),
        .port_data(port_data), .discard_cnt(discard_cnt)
    );

    int    cyc = 0;
    int    tests = 0;
    int    fails = 0;
    int    exp_cnt = 0;
    int    slotn = 0;
    string cur_req = "R1";

    logic [1:0]       pend_fmt = '0;
    logic [NP*HW-1:0] pend_value = '0;

    // {cycle[31:0], port[1:0], soc, data[7:0]}
    logic [42:0] expq[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int model_port(input logic [31:0] h,
                                      input logic [NP*HW-1:0] v,
                                      input logic [NP*HW-1:0] m);
        for (int p = 0; p < NP; p++) begin
            if (((h ^ v[p*HW +: HW]) & m[p*HW +: HW]) == 32'h0) return p;
        end
        return -1;
    endfunction

    function automatic bit keeps(input int f, input int i);
        case (f)
            0:       return 1'b1;
            1:       return i >= 4;
            2:       return (i >= 4) && (i != 8);
            default: return i >= 9;
        endcase
    endfunction

    function automatic int first_oct(input int f);
        case (f)
            0:       return 0;
            1, 2:    return 4;
            default: return 9;
        endcase
    endfunction

    function automatic logic [7:0] oct_val(input int s, input int i, input logic [31:0] h);
        if (i >= 4 && i <= 7) return h[8*(7-i) +: 8];
        return 8'(s * 29 + i * 11 + 3);
    endfunction

    // Drive one slot; chg_at >= 0 applies the pending settings mid-slot
    task automatic send_slot(input logic [31:0] h, input int chg_at);
        int f, p, c0;
        logic [NP*HW-1:0] v, m;
        logic [NP-1:0] fl;
        f  = int'(cfg_fmt);
        v  = cfg_value;
        m  = cfg_mask;
        fl = port_full;
        p  = model_port(h, v, m);
        for (int i = 0; i < 57; i++) begin
            @(posedge clk);
            #1;
            in_sos  = (i == 0);
            in_data = oct_val(slotn, i, h);
            if (i == chg_at) begin
                cfg_fmt   = pend_fmt;
                cfg_value = pend_value;
            end
            if (i == 0) begin
                c0 = cyc;
                if (p < 0 || fl[p]) begin
                    exp_cnt = (exp_cnt < CMAX) ? exp_cnt + 1 : CMAX;
                end else begin
                    for (int k = 0; k < 57; k++) begin
                        if (keeps(f, k))
                            expq.push_back({32'(c0 + k + 9), 2'(p),
                                            1'(k == first_oct(f)), oct_val(slotn, k, h)});
                    end
                end
            end
        end
        slotn++;
    endtask

    task automatic drain(input string req);
        repeat (12) @(posedge clk);
        #1;
        in_sos = 1'b0;
        check(expq.size() == 0, req, "writes still outstanding", 64'(expq.size()), 0);
        check(int'(discard_cnt) == exp_cnt, req, "discard count",
              64'(discard_cnt), 64'(exp_cnt));
    endtask

    task automatic cfg_a();
        cfg_value = {32'hAAAA_0000, 32'h5555_5555, 32'h0000_ABCD, 32'h1234_0000};
        cfg_mask  = {32'hF0F0_0000, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_0000};
    endtask

    // Output monitor: every write compared with the expected stream (R10, R13)
    always @(negedge clk) begin
        if (rst_n && (port_wr != '0 || port_soc != '0)) begin
            int p;
            logic [42:0] e;
            p = 0;
            for (int k = 0; k < NP; k++) if (port_wr[k]) p = k;
            if ($countones(port_wr) != 1 || (port_soc & ~port_wr) != '0) begin
                check(1'b0, "R13", "strobe/marker pattern",
                      64'({port_wr, port_soc}), 64'(1));
            end else if (expq.size() == 0) begin
                check(1'b0, cur_req, "unexpected write on port", 64'(p), 64'hFF);
            end else begin
                e = expq.pop_front();
                check({32'(cyc), 2'(p), port_soc[p], port_data} == e, cur_req,
                      "write {cycle,port,soc,data}",
                      64'({32'(cyc), 2'(p), port_soc[p], port_data}), 64'(e));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] hl [6];
        string names [4];
        hl[0] = 32'h1234_ABCD;  // matches port 0 and 1: R3
        hl[1] = 32'h9999_ABCD;  // port 1, upper half don't-care: R2
        hl[2] = 32'h5555_5555;  // port 2 exact
        hl[3] = 32'hA0A0_1111;  // port 3 partial mask
        hl[4] = 32'h0000_0000;  // no match: R4
        hl[5] = 32'h1234_5555;  // port 0
        names[0] = "R6 R2 R3 R4 R10";
        names[1] = "R7 R2 R3 R4 R10";
        names[2] = "R8 R2 R3 R4 R10";
        names[3] = "R9 R2 R3 R4 R10";

        cfg_a();
        repeat (3) @(posedge clk);
        #1;
        check(port_wr == '0 && port_soc == '0, "R1", "strobes in reset",
              64'({port_wr, port_soc}), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(port_wr == '0, "R1", "strobes after reset", 64'(port_wr), 0);
        check(discard_cnt == '0, "R1", "discard count after reset", 64'(discard_cnt), 0);

        // Format sweep, slots back to back
        for (int f = 0; f < 4; f++) begin
            cfg_fmt = 2'(f);
            cur_req = names[f];
            for (int j = 0; j < 6; j++) send_slot(hl[j], -1);
            drain(cur_req);
        end

        // R5: full winning port drops the whole cell, no rerouting
        cur_req   = "R5";
        cfg_fmt   = 2'd1;
        port_full = 4'b0010;
        send_slot(32'h9999_ABCD, -1);
        send_slot(32'h1234_ABCD, -1);
        drain(cur_req);
        port_full = 4'b0001;
        send_slot(32'h1234_ABCD, -1);
        drain(cur_req);
        port_full = '0;

        // R11: mid-slot change waits for the next slot
        cur_req    = "R11";
        cfg_fmt    = 2'd3;
        pend_fmt   = 2'd0;
        pend_value = cfg_value;
        pend_value[31:0] = 32'hFFFF_0000;
        send_slot(32'h1234_0000, 20);
        send_slot(32'h1234_0000, -1);
        send_slot(32'h5555_5555, -1);
        drain(cur_req);
        cfg_a();

        // R12: saturation of the discard counter
        cur_req = "R12";
        repeat (12) send_slot(32'h0000_0000, -1);
        drain(cur_req);
        check(discard_cnt == CW'(CMAX), "R12", "saturated count", 64'(discard_cnt), CMAX);

        // R2: all-don't-care mask on port 3 catches what others miss
        cur_req = "R2 R8";
        cfg_fmt = 2'd2;
        cfg_mask[3*HW +: HW] = 32'h0;
        send_slot(32'h0000_0000, -1);
        send_slot(32'h1234_0000, -1);
        drain(cur_req);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule